// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the operand address for an indexed memory access. It keeps two 32-bit index registers (X and Y), each written through a simple load port. An access begins with a start strobe that latches the index register choice, the arithmetic mode (native or extended) and the offset width (one, two or three bytes). The displacement bytes then arrive one per clock on a byte input qualified by a valid bit, least significant byte first.

When the last byte is accepted, the block assembles the signed offset and sign-extends it from its width. It adds the offset to the chosen index register and registers the sum. In native mode only the low 16 bits of the index take part, the sum wraps modulo 2^16, and the upper half of the result is zero. In extended mode the whole 32-bit register takes part and the sum wraps modulo 2^32. A one-cycle valid strobe marks each new address.

Top module: `idx_ea_gen`

## Requirements
- R1: While rst_n is low at a clock edge, both index registers, the collection state, ea_addr and ea_valid are cleared to zero.
- R2: When idx_ld_en is high at a clock edge, idx_ld_data is written into the register named by idx_ld_sel (0 = X, 1 = Y), and the other register keeps its value.
- R3: ofs_width latched at start sets the byte count: 2'b00 takes one byte, 2'b01 takes two, and 2'b10 or 2'b11 takes three. Bytes are taken least significant first, and only in cycles where disp_valid is high; idle cycles between bytes are allowed.
- R4: The assembled offset is two's complement at its width: an 8-bit 0xFF acts as -1, a 16-bit 0x8000 acts as -32768, and a 24-bit 0x800000 acts as -8388608.
- R5: With ext_mode low (native) at start, ea_addr[15:0] equals (index[15:0] + offset) mod 2^16, ea_addr[31:16] is zero, and index bits 31:16 have no effect.
- R6: With ext_mode high (extended) at start, ea_addr equals (index + offset sign-extended to 32 bits) mod 2^32.
- R7: ea_valid is high for exactly one cycle, the cycle after the last displacement byte is accepted. ea_addr changes only at that edge and holds its value otherwise.
- R8: A start during a collection discards the bytes taken so far and begins a new collection with the newly latched width, mode and register select. A byte presented in the same cycle as start is not taken.
- R9: Displacement bytes presented when no collection is active are ignored: no ea_valid pulse and no change of ea_addr.
- R10: idx_sel latched at start picks the index register used (0 = X, 1 = Y). The register's value at the edge that accepts the last byte is the one added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| idx_ld_en | input | 1 | Write enable for an index register |
| idx_ld_sel | input | 1 | Index register to write (0 = X, 1 = Y) |
| idx_ld_data | input | 32 | Value to write |
| start | input | 1 | Begins a new displacement collection |
| ofs_width | input | 2 | Offset width code, latched at start |
| ext_mode | input | 1 | 1 = extended 32-bit wrap, 0 = native 16-bit wrap; latched at start |
| idx_sel | input | 1 | Index register for the access, latched at start |
| disp_byte | input | 8 | Displacement byte, least significant first |
| disp_valid | input | 1 | disp_byte is valid this cycle |
| ea_addr | output | 32 | Effective address, held between results |
| ea_valid | output | 1 | One-cycle strobe for a new ea_addr |

## Verification
The hardest case to reach is a restart that lands in the middle of a multi-byte collection while a byte is also being offered. It must discard the partial offset, take no byte in the start cycle, and switch width, mode and register select at once. The stimulus reaches it by starting a three-byte extended access on X and feeding one byte. It then raises start with a native one-byte access on Y while disp_valid is high with a decoy byte. The following byte is the only one that counts, so any carry-over of old bytes, settings or the decoy shows up in the address. Native wrap without carry past bit 15 is reached by loading index values whose upper half is non-zero and whose low half sits at the wrap point.

// File: rtl/idx_ea_pkg.sv
// Package: shared widths and width-code decoding for the indexed
// effective address generator. Assumes byte-serial displacement input.
package idx_ea_pkg;

    // Offset width codes as latched at start
    typedef enum logic [1:0] {
        OFS_ONE   = 2'b00,
        OFS_TWO   = 2'b01,
        OFS_THREE = 2'b10,
        OFS_THR_A = 2'b11
    } ofs_width_e;

    // Index of the final byte (bytes minus one) for a width code
    function automatic logic [1:0] final_byte_idx(input logic [1:0] code);
        case (code)
            OFS_ONE: final_byte_idx = 2'd0;
            OFS_TWO: final_byte_idx = 2'd1;
            default: final_byte_idx = 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/idx_regfile.sv
// Index register file: NUM_IDX registers of DATA_W bits, one write port
// and one combinational read port. Assumes a synchronous active-low reset.
module idx_regfile #(
    parameter int DATA_W  = 32,
    parameter int NUM_IDX = 2,
    localparam int SEL_W  = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs_q [NUM_IDX];

    for (genvar g = 0; g < NUM_IDX; g++) begin : g_reg
        // Holds one index register; cleared in reset, written on a matching load
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(g)))
                regs_q[g] <= wr_data;
        end
    end

    // Read port selects the register used for the access
    always_comb rd_data = regs_q[rd_sel];

    // R2: a load lands in the addressed register
    p_load_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs_q[$past(wr_sel)] == $past(wr_data));

endmodule

// File: rtl/disp_collector.sv
// Displacement collector: latches width, mode and register select at start,
// then gathers BYTE_W-bit bytes least significant first. It exposes the
// merged offset including the byte taken this cycle and flags the last byte.
// Assumes start has priority over a byte in the same cycle.
module disp_collector
    import idx_ea_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 3,
    parameter int SEL_W     = 1,
    localparam int DISP_W   = BYTE_W * MAX_BYTES,
    localparam int CNT_W    = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        width_in,
    input  logic              ext_in,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              byte_vld,
    output logic [DISP_W-1:0] ofs_merged,
    output logic [1:0]        width_q,
    output logic              ext_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic              take_last
);

    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DISP_W-1:0] acc_q;
    logic [CNT_W-1:0]  last_cnt;
    logic              take;

    // Final byte position for the latched width
    always_comb last_cnt = CNT_W'(final_byte_idx(width_q));

    // A byte is taken only inside a collection and never on a start cycle
    always_comb take = busy_q && byte_vld && !start;
    always_comb take_last = take && (cnt_q == last_cnt);

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
        // Places the incoming byte in its lane; other lanes keep gathered bytes
        always_comb ofs_merged[g*BYTE_W +: BYTE_W] =
            (take && cnt_q == CNT_W'(g)) ? byte_in : acc_q[g*BYTE_W +: BYTE_W];
    end

    // Collection state: restart on start, advance on each taken byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            acc_q   <= '0;
            width_q <= 2'b00;
            ext_q   <= 1'b0;
            sel_q   <= '0;
        end else if (start) begin
            busy_q  <= 1'b1;
            cnt_q   <= '0;
            acc_q   <= '0;
            width_q <= width_in;
            ext_q   <= ext_in;
            sel_q   <= sel_in;
        end else if (take) begin
            acc_q <= ofs_merged;
            if (cnt_q == last_cnt)
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the byte counter never passes the final position of the width
    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> cnt_q <= last_cnt);

    // R8: a start always opens a fresh collection at byte zero
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy_q && cnt_q == '0);

endmodule

// File: rtl/ea_adder.sv
// Effective address adder: sign-extends the offset from its latched width
// and adds it to the index value, with a native (NAT_W-bit) or extended
// (ADDR_W-bit) wrap. Purely combinational; assumes ADDR_W > DISP_W.
module ea_adder
    import idx_ea_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NAT_W     = 16,
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 3,
    localparam int DISP_W   = BYTE_W * MAX_BYTES,
    localparam int SH_W     = $clog2(DISP_W + 1)
) (
    input  logic [ADDR_W-1:0] idx_val,
    input  logic [DISP_W-1:0] ofs,
    input  logic [1:0]        width,
    input  logic              ext,
    output logic [ADDR_W-1:0] ea
);

    logic [SH_W-1:0]          sh;
    logic [DISP_W-1:0]        aligned;
    logic signed [DISP_W-1:0] ofs_sx;
    logic [ADDR_W-1:0]        ofs_full;
    logic [NAT_W-1:0]         nat_sum;

    // Shift distance that puts the offset's sign bit at the top
    always_comb sh = SH_W'(BYTE_W) *
                     (SH_W'(MAX_BYTES - 1) - SH_W'(final_byte_idx(width)));

    // Sign extension by a left shift followed by an arithmetic right shift
    always_comb begin
        aligned  = ofs << sh;
        ofs_sx   = $signed(aligned) >>> sh;
        ofs_full = {{(ADDR_W - DISP_W){ofs_sx[DISP_W-1]}}, ofs_sx};
    end

    // Native sum uses only the low NAT_W bits, so no carry leaves bit NAT_W-1
    always_comb nat_sum = idx_val[NAT_W-1:0] + ofs_full[NAT_W-1:0];

    // Mode picks the wrap: zero-filled native sum or full-width sum
    always_comb ea = ext ? (idx_val + ofs_full)
                         : {{(ADDR_W - NAT_W){1'b0}}, nat_sum};

endmodule

// File: rtl/idx_ea_gen.sv
// Indexed effective address generator top: index register file, byte
// collector and adder. The address is registered on the edge that takes
// the final displacement byte, and a one-cycle strobe marks it.
// Assumes a synchronous active-low reset and two index registers.
module idx_ea_gen #(
    parameter int ADDR_W    = 32,
    parameter int NAT_W     = 16,
    parameter int BYTE_W    = 8,
    parameter int MAX_BYTES = 3,
    parameter int NUM_IDX   = 2,
    localparam int DISP_W   = BYTE_W * MAX_BYTES,
    localparam int SEL_W    = (NUM_IDX > 1) ? $clog2(NUM_IDX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_ld_en,
    input  logic [SEL_W-1:0]  idx_ld_sel,
    input  logic [ADDR_W-1:0] idx_ld_data,
    input  logic              start,
    input  logic [1:0]        ofs_width,
    input  logic              ext_mode,
    input  logic [SEL_W-1:0]  idx_sel,
    input  logic [BYTE_W-1:0] disp_byte,
    input  logic              disp_valid,
    output logic [ADDR_W-1:0] ea_addr,
    output logic              ea_valid
);

    logic [ADDR_W-1:0] idx_val;
    logic [DISP_W-1:0] ofs_merged;
    logic [1:0]        col_width;
    logic              col_ext;
    logic [SEL_W-1:0]  col_sel;
    logic              take_last;
    logic [ADDR_W-1:0] ea_next;

    idx_regfile #(.DATA_W(ADDR_W), .NUM_IDX(NUM_IDX)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (idx_ld_en),
        .wr_sel  (idx_ld_sel),
        .wr_data (idx_ld_data),
        .rd_sel  (col_sel),
        .rd_data (idx_val)
    );

    disp_collector #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES), .SEL_W(SEL_W)) u_col (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .width_in   (ofs_width),
        .ext_in     (ext_mode),
        .sel_in     (idx_sel),
        .byte_in    (disp_byte),
        .byte_vld   (disp_valid),
        .ofs_merged (ofs_merged),
        .width_q    (col_width),
        .ext_q      (col_ext),
        .sel_q      (col_sel),
        .take_last  (take_last)
    );

    ea_adder #(.ADDR_W(ADDR_W), .NAT_W(NAT_W), .BYTE_W(BYTE_W),
               .MAX_BYTES(MAX_BYTES)) u_add (
        .idx_val (idx_val),
        .ofs     (ofs_merged),
        .width   (col_width),
        .ext     (col_ext),
        .ea      (ea_next)
    );

    // Output register: capture the address and pulse valid on the final byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_addr  <= '0;
            ea_valid <= 1'b0;
        end else begin
            ea_valid <= take_last;
            if (take_last)
                ea_addr <= ea_next;
        end
    end

    // R7: the strobe never lasts two cycles
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |=> !ea_valid);

    // R7: the address only moves together with a new strobe
    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ea_addr) |-> ea_valid);

    // R5: a native result carries nothing above the native width
    p_native_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_valid && !col_ext) |-> ea_addr[ADDR_W-1:NAT_W] == '0);

endmodule

// File: tb/idx_ea_gen_tb_top.sv
// Directed bench for the indexed effective address generator.
module idx_ea_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_ld_en = 1'b0;
    logic        idx_ld_sel = 1'b0;
    logic [31:0] idx_ld_data = '0;
    logic        start = 1'b0;
    logic [1:0]  ofs_width = 2'b00;
    logic        ext_mode = 1'b0;
    logic        idx_sel = 1'b0;
    logic [7:0]  disp_byte = '0;
    logic        disp_valid = 1'b0;
    logic [31:0] ea_addr;
    logic        ea_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    idx_ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .idx_ld_en(idx_ld_en), .idx_ld_sel(idx_ld_sel),
        .idx_ld_data(idx_ld_data), .start(start), .ofs_width(ofs_width),
        .ext_mode(ext_mode), .idx_sel(idx_sel), .disp_byte(disp_byte),
        .disp_valid(disp_valid), .ea_addr(ea_addr), .ea_valid(ea_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference: sign-extend n bytes of off, add with the mode's wrap
    function automatic logic [31:0] ref_ea(input logic [31:0] idx, input logic [23:0] off,
                                           input int n, input bit ext);
        logic [31:0] sx;
        case (n)
            1:       sx = {{24{off[7]}}, off[7:0]};
            2:       sx = {{16{off[15]}}, off[15:0]};
            default: sx = {{8{off[23]}}, off[23:0]};
        endcase
        if (ext) return idx + sx;
        return {16'h0000, idx[15:0] + sx[15:0]};
    endfunction

    function automatic logic [1:0] code_of(input int n);
        return (n == 1) ? 2'b00 : (n == 2) ? 2'b01 : 2'b10;
    endfunction

    task automatic load(input bit sel, input logic [31:0] val);
        @(negedge clk);
        idx_ld_en = 1'b1; idx_ld_sel = sel; idx_ld_data = val;
        @(negedge clk);
        idx_ld_en = 1'b0;
    endtask

    // Runs one access, then checks the strobe, the address and the hold cycle
    task automatic run(input string req, input bit sel, input int n, input bit ext,
                       input logic [23:0] off, input logic [31:0] idx, input bit gaps);
        logic [31:0] exp;
        exp = ref_ea(idx, off, n, ext);
        @(negedge clk);
        start = 1'b1; ofs_width = code_of(n); ext_mode = ext; idx_sel = sel;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (gaps && i > 0) begin
                disp_valid = 1'b0; disp_byte = 8'hA5;
                @(negedge clk);
                chk({req, " no strobe in gap"}, {31'b0, ea_valid}, 32'd0);
            end
            disp_valid = 1'b1; disp_byte = off[i*8 +: 8];
            @(negedge clk);
            if (i < n - 1) chk({req, " no early strobe"}, {31'b0, ea_valid}, 32'd0);
        end
        disp_valid = 1'b0;
        chk({req, " strobe"}, {31'b0, ea_valid}, 32'd1);
        chk({req, " address"}, ea_addr, exp);
        @(negedge clk);
        chk({req, " R7 strobe drops"}, {31'b0, ea_valid}, 32'd0);
        chk({req, " R7 address holds"}, ea_addr, exp);
    endtask

    task automatic t_reset();
        load(1'b0, 32'hDEAD_BEEF);
        load(1'b1, 32'h1234_5678);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        chk("R1 valid after reset", {31'b0, ea_valid}, 32'd0);
        chk("R1 address after reset", ea_addr, 32'd0);
        run("R1 X cleared", 1'b0, 1, 1'b1, 24'h0, 32'h0, 1'b0);
        run("R1 Y cleared", 1'b1, 1, 1'b1, 24'h0, 32'h0, 1'b0);
    endtask

    task automatic t_load_select();
        load(1'b0, 32'h0101_0101);
        load(1'b1, 32'h8000_0040);
        run("R2 R10 X read", 1'b0, 1, 1'b1, 24'h0, 32'h0101_0101, 1'b0);
        run("R2 R10 Y read", 1'b1, 1, 1'b1, 24'h0, 32'h8000_0040, 1'b0);
        load(1'b1, 32'h0000_1000);
        run("R2 X untouched", 1'b0, 1, 1'b1, 24'h0, 32'h0101_0101, 1'b0);
    endtask

    task automatic t_native();
        load(1'b0, 32'h0001_0000);
        run("R4 R5 FF is -1 native", 1'b0, 1, 1'b0, 24'h0000FF, 32'h0001_0000, 1'b0);
        load(1'b1, 32'h1234_FFFF);
        run("R5 no carry past 15", 1'b1, 1, 1'b0, 24'h000001, 32'h1234_FFFF, 1'b0);
        run("R3 R5 two byte native", 1'b1, 2, 1'b0, 24'h008000, 32'h1234_FFFF, 1'b0);
        run("R3 R5 three byte native", 1'b1, 3, 1'b0, 24'h7F0102, 32'h1234_FFFF, 1'b1);
    endtask

    task automatic t_extended();
        load(1'b0, 32'h0001_0000);
        run("R4 R6 FF is -1 ext", 1'b0, 1, 1'b1, 24'h0000FF, 32'h0001_0000, 1'b0);
        run("R3 R6 two byte ext", 1'b0, 2, 1'b1, 24'h008000, 32'h0001_0000, 1'b1);
        run("R3 R6 three byte ext neg", 1'b0, 3, 1'b1, 24'h800000, 32'h0001_0000, 1'b0);
        run("R3 R6 three byte ext pos", 1'b0, 3, 1'b1, 24'h7FFFFF, 32'h0001_0000, 1'b1);
        load(1'b1, 32'hFFFF_FFFF);
        run("R6 wrap 2^32", 1'b1, 1, 1'b1, 24'h000001, 32'hFFFF_FFFF, 1'b0);
    endtask

    // Width code 2'b11 also takes three bytes
    task automatic t_code11();
        logic [31:0] exp;
        exp = ref_ea(32'h0000_0100, 24'hFFFFFE, 3, 1'b1);
        load(1'b0, 32'h0000_0100);
        @(negedge clk);
        start = 1'b1; ofs_width = 2'b11; ext_mode = 1'b1; idx_sel = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            disp_valid = 1'b1; disp_byte = (i == 0) ? 8'hFE : 8'hFF;
            @(negedge clk);
        end
        disp_valid = 1'b0;
        chk("R3 code 11 strobe", {31'b0, ea_valid}, 32'd1);
        chk("R3 code 11 address", ea_addr, exp);
    endtask

    // Restart mid-collection with a decoy byte on the start cycle
    task automatic t_restart();
        logic [31:0] exp;
        load(1'b0, 32'h0000_5000);
        load(1'b1, 32'hABCD_0010);
        exp = ref_ea(32'hABCD_0010, 24'h0000F0, 1, 1'b0);
        @(negedge clk);
        start = 1'b1; ofs_width = 2'b10; ext_mode = 1'b1; idx_sel = 1'b0;
        @(negedge clk);
        start = 1'b0; disp_valid = 1'b1; disp_byte = 8'h11;
        @(negedge clk);
        start = 1'b1; ofs_width = 2'b00; ext_mode = 1'b0; idx_sel = 1'b1;
        disp_byte = 8'h77;
        @(negedge clk);
        start = 1'b0;
        chk("R8 decoy byte not taken", {31'b0, ea_valid}, 32'd0);
        disp_byte = 8'hF0;
        @(negedge clk);
        disp_valid = 1'b0;
        chk("R8 restart strobe", {31'b0, ea_valid}, 32'd1);
        chk("R8 restart address", ea_addr, exp);
    endtask

    // Bytes with no collection open are ignored
    task automatic t_stray();
        logic [31:0] held;
        held = ea_addr;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            disp_valid = 1'b1; disp_byte = 8'(i * 3 + 1);
            @(negedge clk);
            chk("R9 stray byte no strobe", {31'b0, ea_valid}, 32'd0);
        end
        disp_valid = 1'b0;
        @(negedge clk);
        chk("R9 address unchanged", ea_addr, held);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load_select();
        t_native();
        t_extended();
        t_code11();
        t_restart();
        t_stray();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule